// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Channel

This block takes stereo sample pairs from a host and shifts them out on a single serial data line in the standard two-channel audio format. The bit clock and the word-select line come from outside, and the block follows both. The host writes a left sample and then a right sample through a small synchronous register port. Each completed pair goes into a 16-entry queue. At each left-slot boundary, while the path is running, the serializer takes one pair from the queue. It sends the left word while word-select is low and the right word while word-select is high, most significant bit first.

The host programs the word length, an empty-threshold level and interrupt masks. It reads back a status word that holds the threshold flag and an overrun flag. The queue is refilled when the threshold flag rises. Three enable bits control the path: global, block and channel. Dropping the global or the block bit stops the output, clears the queue and discards the word in progress. A write-only flush bit empties the queue.

The bit clock and word-select are brought into the system clock domain through a two-stage synchronizer. The data output changes only after a falling edge of the bit clock, so it is settled by the next rising edge.

Top module: `stereo_ser_tx`

## Requirements
- R1: The first data bit of a slot is the MSB of the word, driven one bit-clock period after the word-select change. Each following bit is driven after the next falling bit-clock edge. Left data goes out while word-select is 0 and right data while it is 1.
- R2: A write to address 0x0 stores a left word and pushes nothing. A write to address 0x1 pushes one entry made of the stored left word and the written right word.
- R3: A data write (address 0x0 or 0x1) while the queue holds 16 entries changes nothing in the queue and sets the overrun flag (status bit 1). A read of address 0x8 clears the flag.
- R4: Status bit 0 is 1 exactly when the queue level is less than or equal to the 4-bit threshold at address 0x4 (bits 3:0, reset value 8).
- R5: After reset, status (address 0x7) reads 0x1, the mask at address 0x5 reads 0x3, the word-length code reads 5, the irq output is 0 and sd_out is 0.
- R6: Word-length code (address 0x3, bits 2:0) 1, 2, 3 and 4 select 12, 16, 20 and 24 bits. Codes 0, 5, 6 and 7 select 32 bits. The word is taken from the low bits of the written value.
- R7: Slot bits after the programmed word length are 0. A left boundary that finds the queue empty sends zeros in both slots of that frame.
- R8: After the channel is enabled (control address 0x2: bit 0 global, bit 1 block, bit 2 channel; reset value 0x4), data starts only at the next left slot. The slot in progress stays at zero.
- R9: While global or block enable is 0, sd_out is 0, the queue is held empty and data writes are dropped. Disabling mid-word discards the rest of that word and the right word of the same pair.
- R10: Writing 1 to bit 0 of address 0x6 empties the queue.
- R11: irq is 1 when the threshold flag is 1 and mask bit 0 is 0, or when the overrun flag is 1 and mask bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial bit clock |
| ws_in | input | 1 | External word select, 0 = left |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data |
| sd_out | output | 1 | Serial audio data |
| irq | output | 1 | Masked interrupt request |

## Verification
A fault in the queue pointers or the level counter shows at the status port within one cycle of the write that disturbs it. The threshold and overrun bits are then wrong at the exact entry counts where they should switch. A fault in the shifter or slot tracking shows on sd_out within one frame, as a word that is shifted, truncated or sent in the wrong channel. The bench captures the serial stream the way a receiver would and compares whole slots against words built from the requirements. A fault in the enable or flush handling shows as data appearing in a slot that must stay silent. That is visible one to three slots after the control write.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LEFT  = 4'h0,
    A_RIGHT = 4'h1,
    A_CTRL  = 4'h2,
    A_WLEN  = 4'h3,
    A_THR   = 4'h4,
    A_MASK  = 4'h5,
    A_FLUSH = 4'h6,
    A_STAT  = 4'h7,
    A_OVCLR = 4'h8
  } reg_addr_e;

  // Word-length code to bit count; every other code means full 32 bits.
  function automatic int unsigned slot_bits(input logic [2:0] code);
    case (code)
      3'd1:    slot_bits = 12;
      3'd2:    slot_bits = 16;
      3'd3:    slot_bits = 20;
      3'd4:    slot_bits = 24;
      default: slot_bits = 32;
    endcase
  endfunction
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LVL_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign head    = mem[rp_q];
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + 1'b1;
      if (do_pop)  rp_n = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_in,
  input  logic         ws_in,
  input  logic         run_en,
  input  logic         avail,
  input  logic [2*W-1:0] pair,
  input  logic [2:0]   wlen_code,
  output logic         pop,
  output logic         sd_out
);
  logic [2:0]   sclk_sync;
  logic [1:0]   ws_sync;
  logic         ws_prev_q, ws_prev_n, seen_q, seen_n;
  logic [W-1:0] sh_q, sh_n, rh_q, rh_n;
  logic         sd_q, sd_n;
  logic         fall, ws_now, edge_chg, left_start, right_start;
  int unsigned  nbits;

  function automatic logic [W-1:0] justify(input logic [W-1:0] d, input int unsigned n);
    int unsigned k;
    logic [W-1:0] m;
    k = (n > W) ? W : n;
    m = {W{1'b1}} >> (W - k);
    justify = (d & m) << (W - k);
  endfunction

  assign fall        = sclk_sync[2] & ~sclk_sync[1];
  assign ws_now      = ws_sync[1];
  assign edge_chg    = fall & seen_q & (ws_now != ws_prev_q);
  assign left_start  = edge_chg & ~ws_now;
  assign right_start = edge_chg & ws_now;
  assign nbits       = slot_bits(wlen_code);
  assign sd_out      = sd_q;

  always_comb begin
    ws_prev_n = fall ? ws_now : ws_prev_q;
    seen_n    = seen_q | fall;
    sh_n      = sh_q;
    rh_n      = rh_q;
    sd_n      = sd_q;
    pop       = 1'b0;
    if (!run_en) begin
      sh_n = '0;
      rh_n = '0;
      sd_n = 1'b0;
    end else if (fall) begin
      sd_n = sh_q[W-1];
      sh_n = sh_q << 1;
      if (left_start) begin
        if (avail) begin
          pop  = 1'b1;
          sh_n = justify(pair[2*W-1:W], nbits);
          rh_n = justify(pair[W-1:0], nbits);
        end else begin
          sh_n = '0;
          rh_n = '0;
        end
      end else if (right_start) begin
        sh_n = rh_q;
        rh_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      ws_sync   <= '0;
      ws_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      sh_q      <= '0;
      rh_q      <= '0;
      sd_q      <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[1:0], sclk_in};
      ws_sync   <= {ws_sync[0], ws_in};
      ws_prev_q <= ws_prev_n;
      seen_q    <= seen_n;
      sh_q      <= sh_n;
      rh_q      <= rh_n;
      sd_q      <= sd_n;
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              ws_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_out,
  output logic              irq
);
  logic [1:0]          rst_pipe;
  logic                rst_n_i;
  logic [2:0]          ctrl_q, ctrl_n, wlen_q, wlen_n;
  logic [THR_W-1:0]    thr_q, thr_n;
  logic [1:0]          mask_q, mask_n;
  logic [DATA_W-1:0]   lhold_q, lhold_n;
  logic                ovr_q, ovr_n;
  logic                path_on, run_en, wr_left, wr_right, wr_dat, drop, push, pop, flush;
  logic                ovr_clr, thr_flag, fifo_full, fifo_empty;
  logic [LVL_W-1:0]    fifo_level;
  logic [2*DATA_W-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  assign path_on  = ctrl_q[0] & ctrl_q[1];
  assign run_en   = path_on & ctrl_q[2];
  assign wr_left  = wr_en && (wr_addr == A_LEFT);
  assign wr_right = wr_en && (wr_addr == A_RIGHT);
  assign wr_dat   = wr_left | wr_right;
  assign drop     = wr_dat & path_on & fifo_full;
  assign push     = wr_right & path_on & ~fifo_full;
  assign flush    = ~path_on | (wr_en && (wr_addr == A_FLUSH) && wr_data[0]);
  assign ovr_clr  = rd_en && (rd_addr == A_OVCLR);
  assign thr_flag = (fifo_level <= LVL_W'(thr_q));
  assign irq      = (thr_flag & ~mask_q[0]) | (ovr_q & ~mask_q[1]);

  always_comb begin
    ctrl_n  = ctrl_q;
    wlen_n  = wlen_q;
    thr_n   = thr_q;
    mask_n  = mask_q;
    lhold_n = lhold_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_n = wr_data[2:0];
        A_WLEN: wlen_n = wr_data[2:0];
        A_THR:  thr_n  = wr_data[THR_W-1:0];
        A_MASK: mask_n = wr_data[1:0];
        default: ;
      endcase
    end
    if (wr_left && path_on && !fifo_full) lhold_n = wr_data;
    if (drop)         ovr_n = 1'b1;
    else if (ovr_clr) ovr_n = 1'b0;
    else              ovr_n = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q  <= 3'b100;
      wlen_q  <= 3'd5;
      thr_q   <= THR_W'(DEPTH / 2);
      mask_q  <= 2'b11;
      lhold_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      wlen_q  <= wlen_n;
      thr_q   <= thr_n;
      mask_q  <= mask_n;
      lhold_q <= lhold_n;
      ovr_q   <= ovr_n;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(ctrl_q);
      A_WLEN:  rd_data = DATA_W'(wlen_q);
      A_THR:   rd_data = DATA_W'(thr_q);
      A_MASK:  rd_data = DATA_W'(mask_q);
      A_STAT:  rd_data = DATA_W'({ovr_q, thr_flag});
      A_OVCLR: rd_data = DATA_W'(ovr_q);
      default: rd_data = '0;
    endcase
  end

  stx_fifo #(.WIDTH(2*DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_i), .flush(flush), .push(push),
    .push_data({lhold_q, wr_data}), .pop(pop), .head(head),
    .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );

  stx_serializer #(.W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n_i), .sclk_in(sclk_in), .ws_in(ws_in),
    .run_en(run_en), .avail(~fifo_empty), .pair(head), .wlen_code(wlen_q),
    .pop(pop), .sd_out(sd_out)
  );
endmodule

// File: rtl/stx_chk.sv
module stx_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             path_on,
  input logic             sd_out,
  input logic [LVL_W-1:0] level,
  input logic             push,
  input logic             pop,
  input logic             flush,
  input logic             full,
  input logic             wr_dat,
  input logic             ovr,
  input logic             ovr_clr
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && full && path_on) |=> ovr);

  p_ovr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(wr_dat && full && path_on)) |=> !ovr);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !path_on |=> !sd_out);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !flush) |=> $stable(level));
endmodule

bind stereo_ser_tx stx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .path_on(path_on), .sd_out(sd_out),
  .level(fifo_level), .push(push), .pop(pop), .flush(flush),
  .full(fifo_full), .wr_dat(wr_dat), .ovr(ovr_q), .ovr_clr(ovr_clr)
);

// File: tb/stereo_ser_tx_bench.sv
module stereo_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b1, ws_in = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sd_out, irq;

  int n_chk = 0, n_fail = 0;
  int gen_b = 0, slot_cnt = 0, done_id = -1;
  logic gen_ws = 1'b1;
  logic [31:0] slot_word [256];
  logic        slot_ws   [256];
  logic [31:0] cur = '0;
  logic        go = 1'b0;

  always #2.5 clk = ~clk;

  stereo_ser_tx u_stereo_ser_tx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ws_in(ws_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sd_out(sd_out), .irq(irq)
  );

  // Vectors: {word-length code, left, right}
  localparam logic [66:0] VEC [7] = '{
    {3'd5, 32'hA5C3_0F81, 32'h1234_5678},
    {3'd1, 32'hFFFF_FABC, 32'h0000_0123},
    {3'd2, 32'h0BAD_8001, 32'h7777_4321},
    {3'd3, 32'hC00F_1235, 32'h8889_ABCD},
    {3'd4, 32'h5500_FEDC, 32'hFF81_0203},
    {3'd0, 32'h8000_0001, 32'h7FFF_FFFE},
    {3'd7, 32'hDEAD_BEEF, 32'h0F0F_F0F0}
  };

  function automatic logic [31:0] expect_word(input logic [2:0] code, input logic [31:0] d);
    int n;
    case (code)
      3'd1: n = 12; 3'd2: n = 16; 3'd3: n = 20; 3'd4: n = 24;
      default: n = 32;
    endcase
    expect_word = (d & (32'hFFFF_FFFF >> (32 - n))) << (32 - n);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_pos(input logic w, input int b);
    while (!(gen_ws == w && gen_b == b)) @(negedge clk);
  endtask

  task automatic wait_done(input int id);
    while (done_id < id) @(negedge clk);
  endtask

  // Serial bit clock and word select source plus receiver capture (rising edge).
  initial begin
    wait (go);
    forever begin
      for (int b = 0; b < 32; b++) begin
        repeat (8) @(negedge clk);
        sclk_in = 1'b0;
        if (b == 0) begin
          ws_in = ~ws_in;
          slot_cnt++;
        end
        gen_b = b; gen_ws = ws_in;
        repeat (8) @(negedge clk);
        if (b == 0) begin
          if (slot_cnt > 1) begin
            slot_word[(slot_cnt-1) % 256] = cur | {31'b0, sd_out};
            slot_ws[(slot_cnt-1) % 256] = ~ws_in;
            done_id = slot_cnt - 1;
          end
          cur = '0;
        end else begin
          cur[32-b] = sd_out;
        end
        sclk_in = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5 reset state
    rd(4'h7, v); chk("R5 status", v, 32'h1);
    rd(4'h5, v); chk("R5 mask", v, 32'h3);
    rd(4'h3, v); chk("R5 wlen", v, 32'h5);
    rd(4'h4, v); chk("R4 R5 threshold reset", v, 32'h8);
    chk("R5 irq", {31'b0, irq}, 32'h0);
    chk("R5 sd", {31'b0, sd_out}, 32'h0);
    go = 1'b1;

    // R1 R6 R7 vector table
    foreach (VEC[i]) begin
      wr(4'h2, 32'h0);
      wr(4'h3, {29'b0, VEC[i][66:64]});
      wait_pos(1'b1, 2);
      s = slot_cnt;
      wr(4'h2, 32'h7);
      wr(4'h0, VEC[i][63:32]);
      wr(4'h1, VEC[i][31:0]);
      wait_done(s + 3);
      chk("R1 left ws low", {31'b0, slot_ws[(s+1)%256]}, 32'h0);
      chk("R1 R6 left word", slot_word[(s+1)%256], expect_word(VEC[i][66:64], VEC[i][63:32]));
      chk("R1 R6 right word", slot_word[(s+2)%256], expect_word(VEC[i][66:64], VEC[i][31:0]));
      chk("R7 underrun zero", slot_word[(s+3)%256], 32'h0);
    end

    // R8 enable mid left slot: data waits for next left slot
    wr(4'h2, 32'h0);
    wr(4'h3, 32'h5);
    wait_pos(1'b0, 3);
    s = slot_cnt;
    wr(4'h2, 32'h7);
    wr(4'h0, 32'hCAFE_0001);
    wr(4'h1, 32'hCAFE_0002);
    wait_done(s + 2);
    chk("R8 current left silent", slot_word[s%256], 32'h0);
    chk("R8 right silent", slot_word[(s+1)%256], 32'h0);
    chk("R8 next left data", slot_word[(s+2)%256], 32'hCAFE_0001);

    // R9 disable mid word loses the rest
    wait_pos(1'b1, 2);
    s = slot_cnt;
    wr(4'h0, 32'hF0E1_D2C3); wr(4'h1, 32'hB4A5_9687);
    wr(4'h0, 32'h1111_2222); wr(4'h1, 32'h3333_4444);
    while (!(slot_cnt == s + 1 && gen_b == 10)) @(negedge clk);
    wr(4'h2, 32'h0);
    wr(4'h2, 32'h7);
    wait_done(s + 3);
    chk("R9 head of word kept", {24'b0, slot_word[(s+1)%256][31:24]}, 32'hF0);
    chk("R9 tail of word lost", {16'b0, slot_word[(s+1)%256][15:0]}, 32'h0);
    chk("R9 right lost", slot_word[(s+2)%256], 32'h0);
    chk("R9 queue flushed", slot_word[(s+3)%256], 32'h0);

    // R9 writes dropped while block disabled
    wr(4'h2, 32'h1);
    wr(4'h0, 32'h1); wr(4'h1, 32'h2);
    wr(4'h2, 32'h3);
    wr(4'h4, 32'h0);
    rd(4'h7, v); chk("R9 write while off dropped", v, 32'h1);

    // R2 R4 threshold with channel off (no draining)
    wr(4'h4, 32'h8);
    for (int i = 0; i < 8; i++) begin
      wr(4'h0, 32'h1000 + i); wr(4'h1, 32'h2000 + i);
    end
    rd(4'h7, v); chk("R4 level 8 at threshold", v, 32'h1);
    wr(4'h0, 32'h1008);
    rd(4'h7, v); chk("R2 left alone pushes nothing", v, 32'h1);
    wr(4'h1, 32'h2008);
    rd(4'h7, v); chk("R4 level 9 above threshold", v, 32'h0);
    for (int i = 9; i < 16; i++) begin
      wr(4'h0, 32'h1000 + i); wr(4'h1, 32'h2000 + i);
    end
    rd(4'h7, v); chk("R3 full no overrun yet", v, 32'h0);
    wr(4'h1, 32'hDEAD_0000);
    rd(4'h7, v); chk("R3 overrun set", v, 32'h2);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h5, 32'h1);
    @(negedge clk);
    chk("R11 irq overrun unmasked", {31'b0, irq}, 32'h1);
    rd(4'h8, v); chk("R3 clear read value", v, 32'h1);
    rd(4'h7, v); chk("R3 overrun cleared", v, 32'h0);
    chk("R11 irq after clear", {31'b0, irq}, 32'h0);

    // R3 full queue kept its contents
    wait_pos(1'b1, 2);
    s = slot_cnt;
    wr(4'h2, 32'h7);
    wait_done(s + 2);
    chk("R3 first entry left", slot_word[(s+1)%256], 32'h1000);
    chk("R3 first entry right", slot_word[(s+2)%256], 32'h2000);

    // R10 flush
    wr(4'h2, 32'h3);
    wr(4'h4, 32'h0);
    rd(4'h7, v); chk("R10 before flush", v, 32'h0);
    wr(4'h6, 32'h1);
    rd(4'h7, v); chk("R10 after flush", v, 32'h1);
    wr(4'h5, 32'h2);
    @(negedge clk);
    chk("R11 irq threshold unmasked", {31'b0, irq}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule